// File: doc/BRIEF.md
# DMA Dispatcher Control Block

This block is the control-and-status front end of a scatter-gather DMA dispatcher. Software writes a small control word that decides whether the dispatcher may hand descriptors to its read and write engines, and whether it may send them commands. The block turns that word, together with events from the write engine, into two issue-enable outputs. It also keeps a stop bit that hardware can set by itself, a soft-reset sequence that it drives towards both engines, and a masked interrupt latch.

Hardware sets the stop bit when the write engine reports an error or an oversize packet and the matching policy bit is on. A soft reset clears every control bit, including the reset request bit. While it runs, the block raises a resetting flag until both engines confirm they are done and a minimum number of cycles has passed. The interrupt enable acts before the interrupt latch, so events that arrive while it is off are dropped and not kept pending.

Top module: `dma_disp_ctrl`

## Requirements
- R1: After the hardware reset the control word reads 0, the status word reads 0, `descIssueEn` and `cmdIssueEn` are 1, and `irqOut`, `stoppedFlag`, `resettingFlag` and `hostRstReq` are 0.
- R2: The control word is at byte address 0x4. Bits 5:0 read back the value written, from the edge of the write onwards, and bits 31:6 always read 0. The bit fields are: bit 0 stop, bit 1 soft reset, bit 2 stop-on-error, bit 3 stop-on-oversize, bit 4 interrupt enable, bit 5 hold descriptors.
- R3: While the stop bit (bit 0) is 1, both `cmdIssueEn` and `descIssueEn` are 0, starting in the cycle after the write edge.
- R4: While the hold-descriptors bit (bit 5) is 1 and the stop bit is 0, `descIssueEn` is 0 and `cmdIssueEn` stays 1. Clearing bit 5 sets `descIssueEn` back to 1.
- R5: A `wrErrEvt` pulse sets the stop bit at the next edge when bit 2 is 1. The pulse has no effect when bit 2 is 0.
- R6: A `wrEarlyTermEvt` pulse sets the stop bit at the next edge when bit 3 is 1. The pulse has no effect when bit 3 is 0.
- R7: `stoppedFlag` is registered. It is 1 one cycle after a cycle in which bit 0 or bit 5 was set, `rdIdle` and `wrIdle` were both 1, and no soft reset was pending or running. Otherwise it is 0.
- R8: The status word is at byte address 0x0: bit 0 interrupt, bit 1 stopped, bit 2 resetting. An `irqEvt` pulse sets the interrupt bit and `irqOut` at the next edge only while bit 4 is 1. An event that arrives while bit 4 is 0 is lost, and setting bit 4 later does not raise it.
- R9: Writing 1 to status bit 0 clears the interrupt. Writing 0 there has no effect. If an event and a clear fall in the same cycle, the event wins.
- R10: One edge after a control write with bit 1 set, all control bits read 0, `resettingFlag` and `hostRstReq` are 1, and the interrupt is cleared.
- R11: The resetting state lasts at least RST_MIN_CYC cycles (default 4). It ends at the first edge at which both `rdRstDone` and `wrRstDone` have been seen during the reset (each one is remembered) and the minimum has been met.
- R12: While resetting, register writes and engine events are ignored. The control word reads 0 when the reset ends.
- R13: If a hardware stop event and a software control write that clears bit 0 fall in the same cycle, the stop bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Read data for `regAddr`, combinational |
| irqEvt | input | 1 | Interrupt event pulse from the engines |
| wrErrEvt | input | 1 | Error pulse from the write engine |
| wrEarlyTermEvt | input | 1 | Oversize-packet pulse from the write engine |
| rdIdle | input | 1 | Read engine has nothing in flight |
| wrIdle | input | 1 | Write engine has nothing in flight |
| rdRstDone | input | 1 | Read engine has finished its reset |
| wrRstDone | input | 1 | Write engine has finished its reset |
| descIssueEn | output | 1 | Descriptors may be issued |
| cmdIssueEn | output | 1 | Commands may be issued to the engines |
| hostRstReq | output | 1 | Soft reset request to both engines |
| stoppedFlag | output | 1 | Issue halted and both engines idle |
| resettingFlag | output | 1 | Soft reset in progress |
| irqOut | output | 1 | Interrupt output, equal to the interrupt status bit |

## Verification
Control bits, issue enables and read data change at the edge that takes the write. The bench samples them one time step after that edge. The stopped flag and the interrupt are each one register further on, so they are checked one edge after the cycle that caused them. The resetting flag rises one edge after the write with bit 1 set, and the bench counts the edges until it falls. Every input is driven just after a rising edge and every output is read before the next one, so no result depends on the order of events at a clock edge.

// File: rtl/dma_disp_pkg.sv
package dma_disp_pkg;
  localparam int CTRL_W      = 6;
  localparam int BIT_STOP    = 0;
  localparam int BIT_SRST    = 1;
  localparam int BIT_ERRPOL  = 2;
  localparam int BIT_OVRPOL  = 3;
  localparam int BIT_IRQEN   = 4;
  localparam int BIT_HOLD    = 5;
  localparam int ST_IRQ      = 0;
  localparam int ST_STOPPED  = 1;
  localparam int ST_RESETTING = 2;

  typedef struct packed {
    logic ldCtrl;
    logic clrAll;
    logic hwStop;
    logic irqSet;
    logic irqClr;
    logic inReset;
  } dpStrobe_t;

  typedef enum logic {SEQ_RUN, SEQ_RST} rstSeq_t;
endpackage

// File: rtl/dma_disp_ctl.sv
module dma_disp_ctl
  import dma_disp_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int CTRL_OFS    = 4,
  parameter int STAT_OFS    = 0,
  parameter int RST_MIN_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              wrIrqClrBit,
  input  logic [CTRL_W-1:0] ctrlBits,
  input  logic              irqEvt,
  input  logic              wrErrEvt,
  input  logic              wrEarlyTermEvt,
  input  logic              rdRstDone,
  input  logic              wrRstDone,
  output dpStrobe_t         strobe,
  output logic              resetting
);
  localparam int CNT_W = $clog2(RST_MIN_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_MIN_CYC - 1);

  rstSeq_t        seqQ;
  logic [CNT_W-1:0] cntQ;
  logic           rdSeenQ;
  logic           wrSeenQ;
  logic           hitCtrl;
  logic           hitStat;
  logic           startRst;
  logic           bothDone;
  logic           minMet;

  assign resetting = (seqQ == SEQ_RST);
  assign hitCtrl   = regWrEn && (regAddr == ADDR_W'(CTRL_OFS)) && !resetting;
  assign hitStat   = regWrEn && (regAddr == ADDR_W'(STAT_OFS)) && !resetting;
  assign startRst  = ctrlBits[BIT_SRST] && !resetting;
  assign bothDone  = (rdSeenQ || rdRstDone) && (wrSeenQ || wrRstDone);
  assign minMet    = (cntQ >= CNT_LAST);

  always_comb begin
    strobe         = '0;
    strobe.inReset = resetting;
    strobe.clrAll  = startRst;
    strobe.ldCtrl  = hitCtrl;
    strobe.hwStop  = !resetting &&
                     ((wrErrEvt && ctrlBits[BIT_ERRPOL]) ||
                      (wrEarlyTermEvt && ctrlBits[BIT_OVRPOL]));
    strobe.irqSet  = !resetting && irqEvt && ctrlBits[BIT_IRQEN];
    strobe.irqClr  = hitStat && wrIrqClrBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ    <= SEQ_RUN;
      cntQ    <= '0;
      rdSeenQ <= 1'b0;
      wrSeenQ <= 1'b0;
    end else begin
      case (seqQ)
        SEQ_RUN: begin
          if (startRst) begin
            seqQ    <= SEQ_RST;
            cntQ    <= '0;
            rdSeenQ <= 1'b0;
            wrSeenQ <= 1'b0;
          end
        end
        SEQ_RST: begin
          if (bothDone && minMet) begin
            seqQ <= SEQ_RUN;
          end else begin
            if (!minMet) cntQ <= cntQ + 1'b1;
            if (rdRstDone) rdSeenQ <= 1'b1;
            if (wrRstDone) wrSeenQ <= 1'b1;
          end
        end
        default: seqQ <= SEQ_RUN;
      endcase
    end
  end
endmodule

// File: rtl/dma_disp_dp.sv
module dma_disp_dp
  import dma_disp_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CTRL_OFS = 4,
  parameter int STAT_OFS = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CTRL_W-1:0] wrCtrlData,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdIdle,
  input  logic              wrIdle,
  output logic [CTRL_W-1:0] ctrlBits,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut,
  output logic              stoppedFlag,
  output logic              descIssueEn,
  output logic              cmdIssueEn
);
  localparam int ST_W = 3;

  logic [CTRL_W-1:0] ctrlQ;
  logic              irqQ;
  logic              stoppedQ;
  logic              haltReq;
  logic [ST_W-1:0]   statWord;

  assign ctrlBits = ctrlQ;
  assign haltReq  = ctrlQ[BIT_STOP] || ctrlQ[BIT_HOLD];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (strobe.clrAll) begin
      ctrlQ <= '0;
    end else begin
      if (strobe.ldCtrl) ctrlQ <= wrCtrlData;
      if (strobe.hwStop) ctrlQ[BIT_STOP] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ <= 1'b0;
    end else if (strobe.clrAll || strobe.inReset) begin
      irqQ <= 1'b0;
    end else if (strobe.irqSet) begin
      irqQ <= 1'b1;
    end else if (strobe.irqClr) begin
      irqQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stoppedQ <= 1'b0;
    end else begin
      stoppedQ <= haltReq && rdIdle && wrIdle && !strobe.inReset && !strobe.clrAll;
    end
  end

  assign irqOut      = irqQ;
  assign stoppedFlag = stoppedQ;
  assign cmdIssueEn  = !strobe.inReset && !ctrlQ[BIT_STOP];
  assign descIssueEn = cmdIssueEn && !ctrlQ[BIT_HOLD];

  always_comb begin
    statWord               = '0;
    statWord[ST_IRQ]       = irqQ;
    statWord[ST_STOPPED]   = stoppedQ;
    statWord[ST_RESETTING] = strobe.inReset;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(CTRL_OFS)) begin
      regRdData[CTRL_W-1:0] = ctrlQ;
    end else if (regAddr == ADDR_W'(STAT_OFS)) begin
      regRdData[ST_W-1:0] = statWord;
    end
  end
endmodule

// File: rtl/dma_disp_ctrl.sv
module dma_disp_ctrl
  import dma_disp_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int CTRL_OFS    = 4,
  parameter int STAT_OFS    = 0,
  parameter int RST_MIN_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              irqEvt,
  input  logic              wrErrEvt,
  input  logic              wrEarlyTermEvt,
  input  logic              rdIdle,
  input  logic              wrIdle,
  input  logic              rdRstDone,
  input  logic              wrRstDone,
  output logic              descIssueEn,
  output logic              cmdIssueEn,
  output logic              hostRstReq,
  output logic              stoppedFlag,
  output logic              resettingFlag,
  output logic              irqOut
);
  dpStrobe_t         strobe;
  logic [CTRL_W-1:0] ctrlBits;
  logic              resetting;
  logic              unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:CTRL_W];

  dma_disp_ctl #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS),
    .RST_MIN_CYC(RST_MIN_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .wrIrqClrBit(regWrData[ST_IRQ]), .ctrlBits(ctrlBits),
    .irqEvt(irqEvt), .wrErrEvt(wrErrEvt), .wrEarlyTermEvt(wrEarlyTermEvt),
    .rdRstDone(rdRstDone), .wrRstDone(wrRstDone),
    .strobe(strobe), .resetting(resetting)
  );

  dma_disp_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrCtrlData(regWrData[CTRL_W-1:0]), .regAddr(regAddr),
    .rdIdle(rdIdle), .wrIdle(wrIdle), .ctrlBits(ctrlBits),
    .regRdData(regRdData), .irqOut(irqOut), .stoppedFlag(stoppedFlag),
    .descIssueEn(descIssueEn), .cmdIssueEn(cmdIssueEn)
  );

  assign resettingFlag = resetting;
  assign hostRstReq    = resetting;
endmodule

// File: rtl/dma_disp_chk.sv
module dma_disp_chk
  import dma_disp_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int STAT_OFS    = 0,
  parameter int RST_MIN_CYC = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [CTRL_W-1:0] ctrlBits,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic              wrErrEvt,
  input logic              wrEarlyTermEvt,
  input logic              rdIdle,
  input logic              wrIdle,
  input logic              resettingFlag,
  input logic              stoppedFlag,
  input logic              irqOut
);
  localparam int RC_W = $clog2(RST_MIN_CYC + 2);
  localparam logic [RC_W-1:0] RC_MAX = RC_W'(RST_MIN_CYC + 1);

  logic [RC_W-1:0] resCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resCnt <= '0;
    else if (!resettingFlag) resCnt <= '0;
    else if (resCnt != RC_MAX) resCnt <= resCnt + 1'b1;
  end

  p_err_sets_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!resettingFlag && wrErrEvt && ctrlBits[BIT_ERRPOL] && !ctrlBits[BIT_SRST])
      |=> ctrlBits[BIT_STOP]);

  p_ovr_sets_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!resettingFlag && wrEarlyTermEvt && ctrlBits[BIT_OVRPOL] && !ctrlBits[BIT_SRST])
      |=> ctrlBits[BIT_STOP]);

  p_stopped_needs_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    stoppedFlag |-> $past(rdIdle && wrIdle));

  p_masked_irq_lost_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && !ctrlBits[BIT_IRQEN]) |=> !irqOut);

  p_irq_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !resettingFlag && !ctrlBits[BIT_SRST] &&
     !(regWrEn && regAddr == ADDR_W'(STAT_OFS) && regWrData[ST_IRQ])) |=> irqOut);

  p_srst_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits[BIT_SRST] && !resettingFlag) |=> (resettingFlag && ctrlBits == '0));

  p_min_reset_len_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!resettingFlag && resCnt != '0) |-> (resCnt >= RC_W'(RST_MIN_CYC)));

  p_no_irq_in_reset_r12: assert property (@(posedge clk) disable iff (!rstN)
    resettingFlag |=> !irqOut);
endmodule

bind dma_disp_ctrl dma_disp_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFS(STAT_OFS), .RST_MIN_CYC(RST_MIN_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .ctrlBits(ctrlBits), .regAddr(regAddr),
  .regWrEn(regWrEn), .regWrData(regWrData), .wrErrEvt(wrErrEvt),
  .wrEarlyTermEvt(wrEarlyTermEvt), .rdIdle(rdIdle), .wrIdle(wrIdle),
  .resettingFlag(resettingFlag), .stoppedFlag(stoppedFlag), .irqOut(irqOut)
);

// File: tb/sim_dma_disp_ctrl.sv
module sim_dma_disp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h4;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h0;
  localparam int MIN_RST = 4;

  logic clk = 1'b0;
  logic rstN;
  logic [ADDR_W-1:0] regAddr;
  logic regWrEn;
  logic [DATA_W-1:0] regWrData;
  logic [DATA_W-1:0] regRdData;
  logic irqEvt, wrErrEvt, wrEarlyTermEvt, rdIdle, wrIdle, rdRstDone, wrRstDone;
  logic descIssueEn, cmdIssueEn, hostRstReq, stoppedFlag, resettingFlag, irqOut;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_disp_ctrl u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqEvt(irqEvt),
    .wrErrEvt(wrErrEvt), .wrEarlyTermEvt(wrEarlyTermEvt), .rdIdle(rdIdle),
    .wrIdle(wrIdle), .rdRstDone(rdRstDone), .wrRstDone(wrRstDone),
    .descIssueEn(descIssueEn), .cmdIssueEn(cmdIssueEn), .hostRstReq(hostRstReq),
    .stoppedFlag(stoppedFlag), .resettingFlag(resettingFlag), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wrReg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    cyc();
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitRst(output int n);
    n = 0;
    while (resettingFlag && n < 100) begin
      cyc();
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int n;
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    irqEvt = 0; wrErrEvt = 0; wrEarlyTermEvt = 0;
    rdIdle = 1; wrIdle = 1; rdRstDone = 1; wrRstDone = 1;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1 reset state
    rdReg(A_CTRL, rd); check("R1 ctrl", rd, 0);
    rdReg(A_STAT, rd); check("R1 status", rd, 0);
    check("R1 descIssueEn", descIssueEn, 1);
    check("R1 cmdIssueEn", cmdIssueEn, 1);
    check("R1 irqOut", irqOut, 0);
    check("R1 hostRstReq", hostRstReq, 0);

    // R2 R3 R4 R7 R10 sweep over every control value
    for (int v = 0; v < 64; v++) begin
      logic [5:0] b;
      b = 6'(v);
      wrReg(A_CTRL, {26'h3ffffff, b});
      rdReg(A_CTRL, rd); check("R2 readback", rd, {26'h0, b});
      check("R3 cmdIssueEn", cmdIssueEn, {31'h0, !b[0]});
      check("R4 descIssueEn", descIssueEn, {31'h0, !(b[0] || b[5])});
      cyc();
      check("R7 stopped", stoppedFlag, {31'h0, (b[0] || b[5]) && !b[1]});
      if (b[1]) begin
        check("R10 resetting", resettingFlag, 1);
        check("R10 hostRstReq", hostRstReq, 1);
        rdReg(A_CTRL, rd); check("R10 ctrl cleared", rd, 0);
        waitRst(n);
        check("R11 min length", n, MIN_RST);
      end else begin
        wrReg(A_CTRL, 0);
        cyc();
      end
    end

    // R4 clearing hold resumes issue
    wrReg(A_CTRL, 32'h20);
    check("R4 hold desc", descIssueEn, 0);
    check("R4 cmd still on", cmdIssueEn, 1);
    wrReg(A_CTRL, 32'h0);
    check("R4 resume", descIssueEn, 1);

    // R5 R6 policy sweep
    for (int pol = 0; pol < 2; pol++) begin
      wrReg(A_CTRL, pol ? 32'h4 : 32'h0);
      wrErrEvt = 1; cyc(); wrErrEvt = 0;
      rdReg(A_CTRL, rd); check("R5 stop on error", rd[0], pol);
      check("R5 cmdIssueEn", cmdIssueEn, pol ? 0 : 1);
      wrReg(A_CTRL, pol ? 32'h8 : 32'h0);
      wrEarlyTermEvt = 1; cyc(); wrEarlyTermEvt = 0;
      rdReg(A_CTRL, rd); check("R6 stop on oversize", rd[0], pol);
      check("R6 cmdIssueEn", cmdIssueEn, pol ? 0 : 1);
      wrReg(A_CTRL, 0);
    end

    // R13 hw stop beats software clear
    wrReg(A_CTRL, 32'h4);
    wrErrEvt = 1; wrReg(A_CTRL, 32'h4); wrErrEvt = 0;
    rdReg(A_CTRL, rd); check("R13 hw wins", rd, 32'h5);
    wrReg(A_CTRL, 0);

    // R7 idle combinations
    wrReg(A_CTRL, 32'h1);
    for (int k = 0; k < 4; k++) begin
      rdIdle = k[0]; wrIdle = k[1];
      cyc();
      check("R7 idle combo", stoppedFlag, {31'h0, k[0] && k[1]});
      rdReg(A_STAT, rd); check("R7 status bit", rd[1], k[0] && k[1]);
    end
    wrReg(A_CTRL, 0); cyc();
    check("R7 running not stopped", stoppedFlag, 0);

    // R8 R9 interrupt
    irqEvt = 1; cyc(); irqEvt = 0;
    check("R8 masked event", irqOut, 0);
    wrReg(A_CTRL, 32'h10); cyc();
    check("R8 masked event lost", irqOut, 0);
    irqEvt = 1; cyc(); irqEvt = 0;
    check("R8 irq set", irqOut, 1);
    rdReg(A_STAT, rd); check("R8 status irq", rd[0], 1);
    repeat (3) cyc();
    check("R9 irq held", irqOut, 1);
    wrReg(A_STAT, 32'hfffffffe);
    check("R9 write zero no effect", irqOut, 1);
    wrReg(A_STAT, 32'h1);
    check("R9 w1c", irqOut, 0);
    irqEvt = 1; wrReg(A_STAT, 32'h1); irqEvt = 0;
    check("R9 set wins", irqOut, 1);
    wrReg(A_CTRL, 32'h12); cyc();
    check("R10 irq cleared", irqOut, 0);
    check("R10 resetting", resettingFlag, 1);
    waitRst(n);

    // R11 done handshake, R12 ignored writes
    rdRstDone = 0; wrRstDone = 0;
    wrReg(A_CTRL, 32'h2); cyc();
    check("R11 entered", resettingFlag, 1);
    wrReg(A_CTRL, 32'h21);
    wrErrEvt = 1; irqEvt = 1; cyc(); wrErrEvt = 0; irqEvt = 0;
    repeat (8) cyc();
    rdReg(A_CTRL, rd); check("R12 write ignored", rd, 0);
    check("R11 waits for done", resettingFlag, 1);
    rdRstDone = 1; cyc(); rdRstDone = 0;
    repeat (3) cyc();
    check("R11 one done only", resettingFlag, 1);
    check("R11 hostRstReq", hostRstReq, 1);
    wrRstDone = 1; cyc();
    check("R11 ends on both", resettingFlag, 0);
    check("R11 hostRstReq low", hostRstReq, 0);
    rdRstDone = 1;
    rdReg(A_CTRL, rd); check("R12 ctrl after reset", rd, 0);
    check("R12 cmdIssueEn", cmdIssueEn, 1);
    check("R12 irq", irqOut, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule